// File: doc/BRIEF.md
# Auto-Reload Baud Rate Timer

This block is a 16-bit up-counter that serves as the bit-rate source for a serial port. It advances either once every two system clocks or once per falling edge on an external count pin, and only while its run input is high. When the count passes its all-ones value it does not wrap to zero. It loads a 16-bit reload value instead, so the overflow period is set by that value.

A selection stage produces two independent serial clock enables, one for receive and one for transmit. Each direction takes either this timer's overflow divided by 16, or the overflow of an alternate timer. The alternate path is divided by 2, or not divided when a double-rate input is high, and is then divided by 16. A falling edge on a trigger pin can set a sticky flag that raises the interrupt request. While either direction uses this timer, overflow does not set the ordinary overflow flag.

Top module: `baud_reload_timer`

## Requirements
- R1: After reset, cnt_q and rld_q are 0x0000, and ovf_flag, trig_flag, irq, ovf_pulse, rx_tick and tx_tick are all 0.
- R2: With run_en=1 and ext_count_sel=0, cnt_q increases by one on every second clock. The first increment comes on the second clock after run_en rises.
- R3: With run_en=0, cnt_q changes only through a write.
- R4: With run_en=1 and ext_count_sel=1, cnt_q increases by one for each falling edge of count_pin, after a two-flop synchroniser. Rising edges do not count.
- R5: An advance from 0xFFFF loads cnt_q from rld_q and raises ovf_pulse for one clock in the following cycle.
- R6: With rx_use_own=1, rx_tick pulses once per 16 overflows of this timer.
- R7: On the alternate path, one tick is produced per 32 alt_ovf pulses when alt_double=0, and per 16 pulses when alt_double=1.
- R8: rx_use_own selects the source for rx_tick and tx_use_own selects the source for tx_tick, each on its own. The value 1 selects this timer and 0 selects the alternate path.
- R9: With trig_en=1, a falling edge on trig_pin sets trig_flag and irq. With trig_en=0, trig_pin has no effect on either.
- R10: An overflow sets ovf_flag, and with it irq, only when rx_use_own and tx_use_own are both 0.
- R11: A pulse on cnt_wr or rld_wr loads the matching register on the next clock. A counter write in the same cycle as an overflow wins over the reload, and no ovf_pulse results.
- R12: flag_clr clears ovf_flag and trig_flag on the next clock, unless a new set occurs in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Counter runs while high |
| ext_count_sel | input | 1 | 1: count count_pin falling edges, 0: count clk/2 |
| rx_use_own | input | 1 | Receive clock from this timer (1) or alternate path (0) |
| tx_use_own | input | 1 | Transmit clock from this timer (1) or alternate path (0) |
| alt_double | input | 1 | Bypass the divide-by-2 on the alternate path |
| trig_en | input | 1 | Allow trig_pin to set trig_flag |
| count_pin | input | 1 | Asynchronous external count input |
| trig_pin | input | 1 | Asynchronous external trigger input |
| alt_ovf | input | 1 | Overflow pulse of the alternate timer (synchronous) |
| cnt_wr | input | 1 | Load counter from cnt_wdata |
| cnt_wdata | input | 16 | Counter write data |
| rld_wr | input | 1 | Load reload register from rld_wdata |
| rld_wdata | input | 16 | Reload write data |
| flag_clr | input | 1 | Clear both flags |
| cnt_q | output | 16 | Current count |
| rld_q | output | 16 | Current reload value |
| ovf_pulse | output | 1 | One-clock overflow strobe |
| ovf_flag | output | 1 | Sticky overflow flag (non-baud use only) |
| trig_flag | output | 1 | Sticky trigger flag |
| irq | output | 1 | Interrupt request |
| rx_tick | output | 1 | Receive 16x-divided clock enable |
| tx_tick | output | 1 | Transmit 16x-divided clock enable |

## Verification
The assertions check on every cycle that the count holds while stopped, that writes land one clock later, that an overflow strobe always leaves the reload value in the counter, and that neither flag can be set while its gating condition forbids it. The division ratios of the two paths, the independent per-direction source choice, the clk/2 pacing and the edge polarity of the synchronised pins only show up over many cycles. The bench's scenarios show these by counting ticks and edges over fixed windows.

// File: rtl/baud_tmr_pkg.sv
package baud_tmr_pkg;
   typedef enum logic {
      SRC_ALT = 1'b0,
      SRC_OWN = 1'b1
   } clk_src_e;

   function automatic logic pick_src(input clk_src_e sel, input logic own_t, input logic alt_t);
      return (sel == SRC_OWN) ? own_t : alt_t;
   endfunction
endpackage

// File: rtl/baud_edge_sync.sv
module baud_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic fall
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("baud_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_r;
   logic              prev_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_r <= '0;
         prev_r <= 1'b0;
      end else begin
         sync_r <= {sync_r[STAGES-2:0], pin};
         prev_r <= sync_r[STAGES-1];
      end
   end

   assign fall = prev_r & ~sync_r[STAGES-1];
endmodule

// File: rtl/baud_pulse_div.sv
module baud_pulse_div #(
   parameter int DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_pulse,
   output logic out_pulse
);
   generate
      if (DIV < 1) begin : g_bad
         $error("baud_pulse_div: DIV must be at least 1");
      end else if (DIV == 1) begin : g_pass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_pulse <= 1'b0;
            else        out_pulse <= in_pulse;
         end
      end else begin : g_cnt
         localparam int W = $clog2(DIV);
         logic [W-1:0] cnt_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_r     <= '0;
               out_pulse <= 1'b0;
            end else begin
               out_pulse <= 1'b0;
               if (in_pulse) begin
                  if (cnt_r == W'(DIV - 1)) begin
                     cnt_r     <= '0;
                     out_pulse <= 1'b1;
                  end else begin
                     cnt_r <= cnt_r + 1'b1;
                  end
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/baud_reload_timer.sv
module baud_reload_timer
   import baud_tmr_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int BAUD_DIV    = 16,
   parameter int ALT_PREDIV  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             ext_count_sel,
   input  logic             rx_use_own,
   input  logic             tx_use_own,
   input  logic             alt_double,
   input  logic             trig_en,
   input  logic             count_pin,
   input  logic             trig_pin,
   input  logic             alt_ovf,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             rld_wr,
   input  logic [CNT_W-1:0] rld_wdata,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] rld_q,
   output logic             ovf_pulse,
   output logic             ovf_flag,
   output logic             trig_flag,
   output logic             irq,
   output logic             rx_tick,
   output logic             tx_tick
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("baud_reload_timer: CNT_W must be at least 2");
      end
   endgenerate

   logic cnt_fall, trig_fall;
   logic half_ph;
   logic adv, ovf_evt, baud_mode;
   logic own_tick, alt_pre, alt_half, alt_tick;

   baud_edge_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
      .clk(clk), .rst_n(rst_n), .pin(count_pin), .fall(cnt_fall));

   baud_edge_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
      .clk(clk), .rst_n(rst_n), .pin(trig_pin), .fall(trig_fall));

   // half-rate phase, only running in internal mode
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        half_ph <= 1'b0;
      else if (run_en && !ext_count_sel) half_ph <= ~half_ph;
      else                               half_ph <= 1'b0;
   end

   assign adv       = run_en && (ext_count_sel ? cnt_fall : half_ph);
   assign ovf_evt   = adv && (cnt_q == CNT_MAX) && !cnt_wr;
   assign baud_mode = rx_use_own || tx_use_own;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         rld_q     <= '0;
         ovf_pulse <= 1'b0;
      end else begin
         ovf_pulse <= ovf_evt;
         if (rld_wr) rld_q <= rld_wdata;
         if (cnt_wr)       cnt_q <= cnt_wdata;
         else if (ovf_evt) cnt_q <= rld_q;
         else if (adv)     cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_flag  <= 1'b0;
         trig_flag <= 1'b0;
      end else begin
         if (ovf_evt && !baud_mode) ovf_flag <= 1'b1;
         else if (flag_clr)         ovf_flag <= 1'b0;
         if (trig_en && trig_fall)  trig_flag <= 1'b1;
         else if (flag_clr)         trig_flag <= 1'b0;
      end
   end

   assign irq = ovf_flag | trig_flag;

   baud_pulse_div #(.DIV(BAUD_DIV)) u_own_div (
      .clk(clk), .rst_n(rst_n), .in_pulse(ovf_pulse), .out_pulse(own_tick));

   baud_pulse_div #(.DIV(ALT_PREDIV)) u_alt_half (
      .clk(clk), .rst_n(rst_n), .in_pulse(alt_ovf), .out_pulse(alt_half));

   assign alt_pre = alt_double ? alt_ovf : alt_half;

   baud_pulse_div #(.DIV(BAUD_DIV)) u_alt_div (
      .clk(clk), .rst_n(rst_n), .in_pulse(alt_pre), .out_pulse(alt_tick));

   assign rx_tick = pick_src(clk_src_e'(rx_use_own), own_tick, alt_tick);
   assign tx_tick = pick_src(clk_src_e'(tx_use_own), own_tick, alt_tick);
endmodule

// File: rtl/baud_reload_timer_chk.sv
module baud_reload_timer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_en,
   input logic             rx_use_own,
   input logic             tx_use_own,
   input logic             trig_en,
   input logic             cnt_wr,
   input logic [CNT_W-1:0] cnt_wdata,
   input logic             rld_wr,
   input logic [CNT_W-1:0] rld_wdata,
   input logic             flag_clr,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] rld_q,
   input logic             ovf_pulse,
   input logic             ovf_flag,
   input logic             trig_flag
);
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !cnt_wr) |=> $stable(cnt_q));

   p_cnt_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (cnt_q == $past(cnt_wdata)));

   p_rld_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rld_wr |=> (rld_q == $past(rld_wdata)));

   p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> (cnt_q == $past(rld_q)));

   p_baud_noflag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((rx_use_own || tx_use_own) && !ovf_flag) |=> !ovf_flag);

   p_trig_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_en && !trig_flag) |=> !trig_flag);

   p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !trig_en && !run_en) |=> (!trig_flag && !ovf_flag));
endmodule

bind baud_reload_timer baud_reload_timer_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/baud_reload_timer_bench.sv
module baud_reload_timer_bench;
   localparam time CLK_PERIOD = 10ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic run_en = 0, ext_count_sel = 0, rx_use_own = 0, tx_use_own = 0;
   logic alt_double = 0, trig_en = 0, count_pin = 0, trig_pin = 0, alt_ovf = 0;
   logic cnt_wr = 0, rld_wr = 0, flag_clr = 0;
   logic [15:0] cnt_wdata = '0, rld_wdata = '0;
   logic [15:0] cnt_q, rld_q;
   logic ovf_pulse, ovf_flag, trig_flag, irq, rx_tick, tx_tick;

   int n_chk = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   baud_reload_timer u_baud_reload_timer (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr_cnt(input logic [15:0] v);
      @(negedge clk); cnt_wr = 1; cnt_wdata = v;
      @(negedge clk); cnt_wr = 0;
   endtask

   task automatic wr_rld(input logic [15:0] v);
      @(negedge clk); rld_wr = 1; rld_wdata = v;
      @(negedge clk); rld_wr = 0;
   endtask

   task automatic clear_flags();
      @(negedge clk); flag_clr = 1;
      @(negedge clk); flag_clr = 0;
   endtask

   task automatic t_reset();
      check("R1 cnt", cnt_q, 0);
      check("R1 rld", rld_q, 0);
      check("R1 flags", {ovf_flag, trig_flag, irq, ovf_pulse, rx_tick, tx_tick}, 0);
   endtask

   task automatic t_timer_count();
      wr_cnt(16'h0010);
      run_en = 1;
      repeat (20) @(negedge clk);
      run_en = 0;
      check("R2 clk/2 rate", cnt_q, 16'h001A);
   endtask

   task automatic t_hold();
      repeat (10) @(negedge clk);
      check("R3 hold", cnt_q, 16'h001A);
   endtask

   task automatic t_ext_count();
      wr_cnt(16'h0000);
      ext_count_sel = 1; run_en = 1;
      for (int i = 0; i < 5; i++) begin
         count_pin = 1; repeat (4) @(negedge clk);
         count_pin = 0; repeat (4) @(negedge clk);
      end
      count_pin = 1; repeat (6) @(negedge clk);
      check("R4 falling edges", cnt_q, 5);
      run_en = 0; count_pin = 0; repeat (6) @(negedge clk);
      ext_count_sel = 0;
      check("R3 stopped ignores pin", cnt_q, 5);
   endtask

   task automatic t_reload();
      int pulses = 0;
      wr_rld(16'h1234);
      wr_cnt(16'hFFFE);
      run_en = 1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (ovf_pulse) pulses++;
      end
      run_en = 0;
      check("R5 reload value", cnt_q, 16'h1234);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         if (ovf_pulse) pulses++;
      end
      check("R5 one strobe", pulses, 1);
      check("R10 flag set outside baud", ovf_flag, 1);
      check("R10 irq", irq, 1);
      clear_flags();
      check("R12 clear", {ovf_flag, irq}, 0);
   endtask

   task automatic t_own_div();
      int rx_n = 0, tx_n = 0;
      rx_use_own = 1; tx_use_own = 0;
      wr_rld(16'hFFFC);
      wr_cnt(16'hFFFC);
      run_en = 1;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (rx_tick) rx_n++;
         if (tx_tick) tx_n++;
      end
      run_en = 0;
      repeat (4) @(negedge clk);
      check("R6 own div16", rx_n, 3);
      check("R8 tx stays on alt", tx_n, 0);
      check("R10 no flag in baud mode", {ovf_flag, irq}, 0);
      rx_use_own = 0;
   endtask

   task automatic pulse_alt(input int n, output int rx_n, output int tx_n);
      rx_n = 0; tx_n = 0;
      for (int i = 0; i < n; i++) begin
         alt_ovf = 1; @(negedge clk);
         if (rx_tick) rx_n++;
         if (tx_tick) tx_n++;
         alt_ovf = 0;
         repeat (2) begin
            @(negedge clk);
            if (rx_tick) rx_n++;
            if (tx_tick) tx_n++;
         end
      end
      repeat (4) begin
         @(negedge clk);
         if (rx_tick) rx_n++;
         if (tx_tick) tx_n++;
      end
   endtask

   task automatic t_alt_div();
      int rx_n, tx_n;
      alt_double = 0;
      pulse_alt(64, rx_n, tx_n);
      check("R7 alt /32 rx", rx_n, 2);
      check("R7 alt /32 tx", tx_n, 2);
      alt_double = 1;
      pulse_alt(32, rx_n, tx_n);
      check("R7 alt /16 rx", rx_n, 2);
      tx_use_own = 1;
      pulse_alt(32, rx_n, tx_n);
      check("R8 rx on alt", rx_n, 2);
      check("R8 tx on own", tx_n, 0);
      tx_use_own = 0; alt_double = 0;
   endtask

   task automatic t_trig();
      trig_en = 0;
      trig_pin = 1; repeat (4) @(negedge clk);
      trig_pin = 0; repeat (6) @(negedge clk);
      check("R9 disabled trig", {trig_flag, irq}, 0);
      trig_en = 1;
      trig_pin = 1; repeat (4) @(negedge clk);
      trig_pin = 0; repeat (6) @(negedge clk);
      check("R9 trig flag", {trig_flag, irq}, 2'b11);
      trig_en = 0;
      clear_flags();
      check("R12 trig clear", {trig_flag, irq}, 0);
   endtask

   task automatic t_write_wins();
      int pulses = 0;
      wr_rld(16'h7777);
      wr_cnt(16'hFFFF);
      run_en = 1;
      @(negedge clk);
      cnt_wr = 1; cnt_wdata = 16'h0042;
      @(negedge clk);
      cnt_wr = 0; run_en = 0;
      check("R11 write over reload", cnt_q, 16'h0042);
      if (ovf_pulse) pulses++;
      @(negedge clk);
      if (ovf_pulse) pulses++;
      check("R11 no strobe", pulses, 0);
      check("R11 no flag", ovf_flag, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_timer_count();
      t_hold();
      t_ext_count();
      t_reload();
      t_own_div();
      t_alt_div();
      t_trig();
      t_write_wins();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule